// File: doc/BRIEF.md
# PHY Loopback Steering and Carrier-Sense Control

This block sits in the 100 Mb/s receive/transmit core of an Ethernet physical layer. It sends the scrambled NRZI transmit stream to the line-side transmit output and picks the source for the descrambler input. That source is either the line receive path or, during local loopback, the transmit stream itself. Local loopback skips the MLT-3 coder and the analog front end.

A small set of control bits is held inside the block and written one field at a time through a write-enable/data pair. The requested loopback mode and the transmit-mute bit are applied only while both transmit and receive are idle, so that no frame is cut partway through. The block also drives the MII carrier-sense output from the transmit-active and receive-active indications. In full duplex, a select bit chooses whether carrier sense follows transmit or receive.

Top module: `phy_lbk_crs_ctl`

## Requirements
- R1: After reset, lb_mode is 0, line_tx, desc_in and crs are all 0, and the control bits are local=0, remote=0, mute=1, fdx=0, alt=0.
- R2: Control bit positions are local loopback = bit 0, remote loopback = bit 1, transmit mute = bit 2, full duplex = bit 3, alternate carrier select = bit 4. A clock edge with cfg_we[i]=1 loads cfg_wdata[i] into that bit and leaves the bits with cfg_we=0 unchanged.
- R3: In local loopback (lb_mode=1), desc_in takes the value tx_nrzi had at the previous clock edge.
- R4: When local and remote loopback are both set, neither is entered: lb_mode is 0 and the datapath behaves as in R7.
- R5: In any loopback mode (lb_mode 1 or 2) with mute=1, line_tx is all zeros.
- R6: In local loopback with mute=0, both line_tx and desc_in carry tx_nrzi, one cycle late.
- R7: With no loopback (lb_mode=0), line_tx follows tx_nrzi and desc_in follows line_rx, each one cycle late.
- R8: With only remote loopback set, lb_mode is 2 and desc_in follows line_rx. line_tx follows tx_nrzi when mute=0 and is zero when mute=1.
- R9: lb_mode and the applied mute value change only at a clock edge where tx_active and rx_active are both 0. Otherwise the previous routing is held.
- R10: In full duplex with alt=1, crs equals tx_active from the previous edge.
- R11: In full duplex with alt=0, crs equals rx_active from the previous edge.
- R12: In half duplex, crs equals tx_active OR rx_active from the previous edge, whatever the value of alt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 5 | Per-bit write enable for the control bits |
| cfg_wdata | input | 5 | Control bit write data |
| tx_active | input | 1 | Transmit frame in progress |
| rx_active | input | 1 | Receive frame in progress |
| tx_nrzi | input | LANES | Scrambled NRZI transmit symbols |
| line_rx | input | LANES | NRZI symbols from the line receive path |
| line_tx | output | LANES | NRZI symbols toward the line coder |
| desc_in | output | LANES | NRZI symbols into the descrambler |
| crs | output | 1 | MII carrier sense |
| lb_mode | output | 2 | Applied mode: 0 none, 1 local, 2 remote |

## Verification
The bench builds the block with LANES=4, so each vector moves a 4-bit pattern. This makes it possible to tell whether a lane pattern came from the transmit side or from the line side. The carrier-sense and mode logic does not depend on the lane count, so the width mainly makes the routing visible. A mode change requested in mid-frame checks that routing is held until an idle edge. The reset value of the mute bit is seen by enabling local loopback alone, without writing mute.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  typedef enum logic [1:0] {
    LBK_NONE   = 2'd0,
    LBK_LOCAL  = 2'd1,
    LBK_REMOTE = 2'd2
  } lbk_mode_e;

  localparam int CFG_W     = 5;
  localparam int CF_LOCAL  = 0;
  localparam int CF_REMOTE = 1;
  localparam int CF_MUTE   = 2;
  localparam int CF_FDX    = 3;
  localparam int CF_ALT    = 4;
  localparam logic [CFG_W-1:0] CFG_RST = 5'b00100;

  // two loopbacks requested together cancel each other
  function automatic lbk_mode_e resolve_mode(input logic loc, input logic rem);
    lbk_mode_e m;
    case ({loc, rem})
      2'b10:   m = LBK_LOCAL;
      2'b01:   m = LBK_REMOTE;
      default: m = LBK_NONE;
    endcase
    return m;
  endfunction

  function automatic logic crs_value(input logic fdx, input logic alt,
                                     input logic txa, input logic rxa);
    logic v;
    if (!fdx)     v = txa | rxa;
    else if (alt) v = txa;
    else          v = rxa;
    return v;
  endfunction

  // 1 when transmit data may reach the line
  function automatic logic line_pass(input lbk_mode_e m, input logic mute);
    return (m == LBK_NONE) || !mute;
  endfunction

endpackage

// File: rtl/lbk_mode_ctrl.sv
module lbk_mode_ctrl
  import lbk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tx_active,
  input  logic             rx_active,
  output lbk_mode_e        mode_eff,
  output logic             mute_eff,
  output lbk_mode_e        mode_q,
  output logic             fdx,
  output logic             alt
);

  logic [CFG_W-1:0] cfg_q;
  logic             mute_q;
  logic             idle;
  lbk_mode_e        mode_req;

  genvar gi;
  generate
    for (gi = 0; gi < CFG_W; gi++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cfg_q[gi] <= CFG_RST[gi];
        else if (cfg_we[gi]) cfg_q[gi] <= cfg_wdata[gi];
      end
      assert_field_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we[gi] |=> cfg_q[gi] == $past(cfg_wdata[gi]));
      assert_field_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we[gi] |=> $stable(cfg_q[gi]));
    end
  endgenerate

  assign idle     = !tx_active && !rx_active;
  assign mode_req = resolve_mode(cfg_q[CF_LOCAL], cfg_q[CF_REMOTE]);
  assign mode_eff = idle ? mode_req : mode_q;
  assign mute_eff = idle ? cfg_q[CF_MUTE] : mute_q;
  assign fdx      = cfg_q[CF_FDX];
  assign alt      = cfg_q[CF_ALT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LBK_NONE;
      mute_q <= CFG_RST[CF_MUTE];
    end else begin
      mode_q <= mode_eff;
      mute_q <= mute_eff;
    end
  end

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> (mode_q == $past(mode_q)) && (mute_q == $past(mute_q)));
  assert_both_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cfg_q[CF_LOCAL] && cfg_q[CF_REMOTE]) |=> mode_q == LBK_NONE);

endmodule

// File: rtl/lbk_steer.sv
module lbk_steer
  import lbk_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lbk_mode_e        mode_eff,
  input  logic             mute_eff,
  input  logic [LANES-1:0] tx_nrzi,
  input  logic [LANES-1:0] line_rx,
  output logic [LANES-1:0] line_tx,
  output logic [LANES-1:0] desc_in
);

  logic pass;
  logic loop_local;

  assign pass       = line_pass(mode_eff, mute_eff);
  assign loop_local = (mode_eff == LBK_LOCAL);

  genvar li;
  generate
    for (li = 0; li < LANES; li++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          line_tx[li] <= 1'b0;
          desc_in[li] <= 1'b0;
        end else begin
          line_tx[li] <= pass & tx_nrzi[li];
          desc_in[li] <= loop_local ? tx_nrzi[li] : line_rx[li];
        end
      end
    end
  endgenerate

  assert_mute_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff != LBK_NONE && mute_eff) |=> line_tx == '0);
  assert_local_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == LBK_LOCAL) |=> desc_in == $past(tx_nrzi));
  assert_normal_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == LBK_NONE) |=> (line_tx == $past(tx_nrzi)) && (desc_in == $past(line_rx)));
  assert_remote_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == LBK_REMOTE) |=> desc_in == $past(line_rx));

endmodule

// File: rtl/lbk_crs_gen.sv
module lbk_crs_gen
  import lbk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fdx,
  input  logic alt,
  input  logic tx_active,
  input  logic rx_active,
  output logic crs
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crs <= 1'b0;
    else        crs <= crs_value(fdx, alt, tx_active, rx_active);
  end

  assert_fdx_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fdx && alt) |=> crs == $past(tx_active));
  assert_fdx_rx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fdx && !alt) |=> crs == $past(rx_active));
  assert_half_any_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fdx |=> crs == ($past(tx_active) || $past(rx_active)));

endmodule

// File: rtl/phy_lbk_crs_ctl.sv
module phy_lbk_crs_ctl
  import lbk_pkg::*;
#(
  parameter int LANES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cfg_we,
  input  logic [4:0]       cfg_wdata,
  input  logic             tx_active,
  input  logic             rx_active,
  input  logic [LANES-1:0] tx_nrzi,
  input  logic [LANES-1:0] line_rx,
  output logic [LANES-1:0] line_tx,
  output logic [LANES-1:0] desc_in,
  output logic             crs,
  output logic [1:0]       lb_mode
);

  lbk_mode_e mode_eff;
  lbk_mode_e mode_q;
  logic      mute_eff;
  logic      fdx;
  logic      alt;

  lbk_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_active(tx_active), .rx_active(rx_active),
    .mode_eff(mode_eff), .mute_eff(mute_eff), .mode_q(mode_q),
    .fdx(fdx), .alt(alt)
  );

  lbk_steer #(.LANES(LANES)) u_steer (
    .clk(clk), .rst_n(rst_n), .mode_eff(mode_eff), .mute_eff(mute_eff),
    .tx_nrzi(tx_nrzi), .line_rx(line_rx), .line_tx(line_tx), .desc_in(desc_in)
  );

  lbk_crs_gen u_crs (
    .clk(clk), .rst_n(rst_n), .fdx(fdx), .alt(alt),
    .tx_active(tx_active), .rx_active(rx_active), .crs(crs)
  );

  assign lb_mode = mode_q;

  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lb_mode != 2'd3);

endmodule

// File: tb/phy_lbk_crs_ctl_test.sv
module phy_lbk_crs_ctl_test;

  localparam int LANES = 4;
  localparam int NV    = 11;

  typedef struct packed {
    logic [4:0] we;
    logic [4:0] wd;
    logic       ta;
    logic       ra;
    logic [3:0] tx;
    logic [3:0] rx;
    logic [3:0] eline;
    logic [3:0] edesc;
    logic       ecrs;
    logic [1:0] emode;
  } vec_t;

  // control bits: [0] local, [1] remote, [2] mute, [3] fdx, [4] alt
  localparam vec_t VECS [NV] = '{
    '{5'b00000, 5'b00000, 1'b1, 1'b0, 4'hA, 4'h5, 4'hA, 4'h5, 1'b1, 2'd0},
    '{5'b00001, 5'b00001, 1'b1, 1'b0, 4'hC, 4'h3, 4'h0, 4'hC, 1'b1, 2'd1},
    '{5'b00100, 5'b00000, 1'b0, 1'b1, 4'h6, 4'h9, 4'h6, 4'h6, 1'b1, 2'd1},
    '{5'b00010, 5'b00010, 1'b1, 1'b1, 4'hF, 4'h2, 4'hF, 4'h2, 1'b1, 2'd0},
    '{5'b00001, 5'b00000, 1'b1, 1'b0, 4'h3, 4'h8, 4'h3, 4'h8, 1'b1, 2'd2},
    '{5'b00100, 5'b00100, 1'b0, 1'b0, 4'h5, 4'h1, 4'h0, 4'h1, 1'b0, 2'd2},
    '{5'b11010, 5'b01000, 1'b1, 1'b0, 4'h9, 4'h4, 4'h9, 4'h4, 1'b0, 2'd0},
    '{5'b10000, 5'b10000, 1'b1, 1'b0, 4'h2, 4'h7, 4'h2, 4'h7, 1'b1, 2'd0},
    '{5'b00000, 5'b00000, 1'b0, 1'b1, 4'h4, 4'hE, 4'h4, 4'hE, 1'b0, 2'd0},
    '{5'b01000, 5'b00000, 1'b0, 1'b1, 4'h1, 4'hB, 4'h1, 4'hB, 1'b1, 2'd0},
    '{5'b00000, 5'b00000, 1'b0, 1'b0, 4'h7, 4'hD, 4'h7, 4'hD, 1'b0, 2'd0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R7 normal";
      1: return "R3 R5 local muted by reset value";
      2: return "R6 local unmuted";
      3: return "R4 both cancel";
      4: return "R8 remote unmuted";
      5: return "R8 remote muted";
      6: return "R2 R11 fdx rx";
      7: return "R10 fdx tx active";
      8: return "R10 fdx rx only";
      9: return "R12 half rx";
      default: return "R12 half idle";
    endcase
  endfunction

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [4:0]       cfg_we = '0;
  logic [4:0]       cfg_wdata = '0;
  logic             tx_active = 1'b0;
  logic             rx_active = 1'b0;
  logic [LANES-1:0] tx_nrzi = '0;
  logic [LANES-1:0] line_rx = '0;
  logic [LANES-1:0] line_tx;
  logic [LANES-1:0] desc_in;
  logic             crs;
  logic [1:0]       lb_mode;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  phy_lbk_crs_ctl #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_active(tx_active), .rx_active(rx_active), .tx_nrzi(tx_nrzi),
    .line_rx(line_rx), .line_tx(line_tx), .desc_in(desc_in),
    .crs(crs), .lb_mode(lb_mode)
  );

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values visible at the ports
    chk("R1", "line_tx", 8'(line_tx), 8'h0);
    chk("R1", "desc_in", 8'(desc_in), 8'h0);
    chk("R1", "crs", 8'(crs), 8'h0);
    chk("R1", "lb_mode", 8'(lb_mode), 8'h0);
    rst_n = 1'b1;
    cycle();
    chk("R1", "lb_mode after idle", 8'(lb_mode), 8'h0);

    for (int i = 0; i < NV; i++) begin
      cfg_we = VECS[i].we; cfg_wdata = VECS[i].wd;
      tx_active = 1'b0; rx_active = 1'b0;
      cycle();
      cfg_we = '0;
      cycle();
      tx_active = VECS[i].ta; rx_active = VECS[i].ra;
      tx_nrzi = VECS[i].tx; line_rx = VECS[i].rx;
      cycle();
      chk(vec_tag(i), "line_tx", 8'(line_tx), 8'(VECS[i].eline));
      chk(vec_tag(i), "desc_in", 8'(desc_in), 8'(VECS[i].edesc));
      chk(vec_tag(i), "crs", 8'(crs), 8'(VECS[i].ecrs));
      chk(vec_tag(i), "lb_mode", 8'(lb_mode), 8'(VECS[i].emode));
    end

    // R9: request local loopback in mid-frame; routing must hold until idle
    // state now: local0 remote0 mute1 fdx0 alt1, mode none
    tx_active = 1'b1; rx_active = 1'b0;
    tx_nrzi = 4'h5; line_rx = 4'hA;
    cfg_we = 5'b00001; cfg_wdata = 5'b00001;
    cycle();
    cfg_we = '0;
    for (int k = 0; k < 3; k++) begin
      tx_nrzi = 4'(k + 9);
      cycle();
      chk("R9", "lb_mode held busy", 8'(lb_mode), 8'h0);
      chk("R9", "line_tx held normal", 8'(line_tx), 8'(k + 9));
      chk("R9", "desc_in held normal", 8'(desc_in), 8'hA);
    end
    tx_active = 1'b0;
    tx_nrzi = 4'h6;
    cycle();
    chk("R9", "lb_mode at idle", 8'(lb_mode), 8'h1);
    chk("R5", "line_tx muted", 8'(line_tx), 8'h0);
    chk("R3", "desc_in looped", 8'(desc_in), 8'h6);

    // R9: receive activity alone also blocks a change back to normal
    rx_active = 1'b1;
    cfg_we = 5'b00001; cfg_wdata = 5'b00000;
    cycle();
    cfg_we = '0;
    tx_nrzi = 4'h3;
    cycle();
    chk("R9", "lb_mode held rx busy", 8'(lb_mode), 8'h1);
    chk("R3", "desc_in still looped", 8'(desc_in), 8'h3);
    rx_active = 1'b0;
    cycle();
    chk("R9", "lb_mode back to none", 8'(lb_mode), 8'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule